// File: doc/BRIEF.md
# Page Table Walker (single level)

This block turns a 32-bit virtual address into a physical address using a flat, one-level page table kept in memory. Pages and frames are both 4 KB. The low 12 bits of the address are the in-page offset and pass through unchanged. The upper 20 bits form the virtual page number. That number selects one 32-bit table word at `pt_base + vpn*4`, where `pt_base` is the per-process table pointer supplied by a register outside the block.

Each table word holds a frame number in bits [31:12], a 2-bit protection key in [3:2], a dirty flag in bit 1 and an assigned flag in bit 0. If the word is not assigned, the block answers with a missing-page fault. If the key differs from the requester's key, it answers with a protection fault. Otherwise it returns `frame*4096 + offset`. A store that lands on a clean entry first writes the word back with the dirty flag set, and only then responds.

The request side, the response side and the memory command side all use valid/ready. A source holds its valid signal and its payload steady until the matching ready is high on a clock edge. The block does the same on `rsp_*` and `mem_req_*`. Memory read data and write acknowledges return on `mem_rsp_valid` with no back-pressure. The block accepts only one translation at a time.

Top module: `pt_walker`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0.
- R2: The entry read uses address `pt_base + vaddr[31:12]*4`, with `pt_base` sampled when the request is accepted and `mem_req_write` = 0.
- R3: For an entry with bit0 = 1 and key bits [3:2] equal to `req_key`, the response has `rsp_fault` = 0 and `rsp_paddr` = {entry[31:12], vaddr[11:0]}.
- R4: An entry with bit0 = 0 gives `rsp_fault` = 1 (missing page) and `rsp_paddr` = 0, whatever the key, and causes no write.
- R5: An assigned entry whose key differs from `req_key` gives `rsp_fault` = 2 (protection) and `rsp_paddr` = 0, and causes no write.
- R6: A store (`req_store` = 1) that succeeds on an entry with bit1 = 0 issues exactly one write to the same entry address, with data equal to the entry OR 0x2, before the response appears.
- R7: Loads, and stores to entries whose bit1 is already 1, issue no write.
- R8: Only one translation is in flight: `req_ready` is 0 from acceptance until the response is taken.
- R9: While `rsp_valid` is high and `rsp_ready` is low, the response holds steady. While `mem_req_valid` is high and `mem_req_ready` is low, the memory command holds steady.
- R10: A `mem_rsp_valid` pulse that arrives while no memory reply is awaited has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pt_base | input | 32 | Page-table base pointer |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address |
| req_store | input | 1 | 1 = store access, 0 = load |
| req_key | input | 2 | Requester protection key |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes response |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 2 | 0 none, 1 missing page, 2 protection |
| mem_req_valid | output | 1 | Memory command valid |
| mem_req_ready | input | 1 | Memory accepts command |
| mem_req_write | output | 1 | 1 = write-back, 0 = read |
| mem_req_addr | output | 32 | Entry address |
| mem_req_wdata | output | 32 | Write-back data |
| mem_rsp_valid | input | 1 | Read data or write acknowledge |
| mem_rsp_rdata | input | 32 | Entry read data |

## Verification
Some rules are checked by assertions on every cycle. These are the single-request exclusion on the request side, holding the response and the memory command steady under back-pressure, a zero address on missing-page faults, and a set dirty bit in every write-back word. The bench scenarios cover the rest: entry address arithmetic, physical address formation, fault priority, the count of write-backs per access, and the effect of stray memory replies. Those need a memory model and knowledge of the table contents.

// File: rtl/pt_pkg.sv
package pt_pkg;
  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_MISSING = 2'd1,
    FLT_PROT    = 2'd2
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ,
    ST_WR_WAIT,
    ST_RESP
  } walk_state_e;
endpackage

// File: rtl/pt_addr_split.sv
module pt_addr_split #(
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int OFFS_W = 12,
  parameter int ENT_LG = 2
) (
  input  logic [VA_W-1:0]        vaddr,
  input  logic [PA_W-1:0]        base,
  output logic [VA_W-OFFS_W-1:0] vpn,
  output logic [OFFS_W-1:0]      offset,
  output logic [PA_W-1:0]        entry_addr
);
  localparam int VPN_W = VA_W - OFFS_W;

  assign vpn        = vaddr[VA_W-1:OFFS_W];
  assign offset     = vaddr[OFFS_W-1:0];
  assign entry_addr = base + PA_W'({vpn, {ENT_LG{1'b0}}});

  logic unused_w;
  assign unused_w = ^VPN_W;
endmodule

// File: rtl/pt_entry_check.sv
module pt_entry_check #(
  parameter int PTE_W  = 32,
  parameter int OFFS_W = 12,
  parameter int KEY_W  = 2
) (
  input  logic [PTE_W-1:0]        entry,
  input  logic [KEY_W-1:0]        key,
  input  logic                    store,
  output pt_pkg::fault_e          fault,
  output logic                    need_wb,
  output logic [PTE_W-OFFS_W-1:0] frame,
  output logic [PTE_W-1:0]        wb_word
);
  import pt_pkg::*;
  localparam int BIT_ASSIGNED = 0;
  localparam int BIT_DIRTY    = 1;
  localparam int KEY_LO       = 2;

  logic assigned, dirty;
  logic [KEY_W-1:0] ent_key;

  assign assigned = entry[BIT_ASSIGNED];
  assign dirty    = entry[BIT_DIRTY];
  assign ent_key  = entry[KEY_LO +: KEY_W];
  assign frame    = entry[PTE_W-1:OFFS_W];

  always_comb begin
    if (!assigned)           fault = FLT_MISSING;
    else if (ent_key != key) fault = FLT_PROT;
    else                     fault = FLT_NONE;
  end

  assign need_wb = (fault == FLT_NONE) && store && !dirty;

  always_comb begin
    wb_word            = entry;
    wb_word[BIT_DIRTY] = 1'b1;
  end
endmodule

// File: rtl/pt_seq.sv
module pt_seq #(
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int PTE_W  = 32,
  parameter int OFFS_W = 12,
  parameter int KEY_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PA_W-1:0]         pt_base,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [VA_W-1:0]         req_vaddr,
  input  logic                    req_store,
  input  logic [KEY_W-1:0]        req_key,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [PA_W-1:0]         rsp_paddr,
  output logic [1:0]              rsp_fault,
  output logic                    mem_req_valid,
  input  logic                    mem_req_ready,
  output logic                    mem_req_write,
  output logic [PA_W-1:0]         mem_req_addr,
  output logic [PTE_W-1:0]        mem_req_wdata,
  input  logic                    mem_rsp_valid,
  // captured request towards the split / check units
  output logic [VA_W-1:0]         vaddr_q,
  output logic [PA_W-1:0]         base_q,
  output logic [KEY_W-1:0]        key_q,
  output logic                    store_q,
  input  logic [PA_W-1:0]         entry_addr,
  input  logic [OFFS_W-1:0]       offset,
  input  pt_pkg::fault_e          chk_fault,
  input  logic                    chk_need_wb,
  input  logic [PTE_W-OFFS_W-1:0] chk_frame,
  input  logic [PTE_W-1:0]        chk_wb_word
);
  import pt_pkg::*;

  walk_state_e      state;
  logic [PTE_W-1:0] wb_q;
  logic [PA_W-1:0]  paddr_q;
  fault_e           fault_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      vaddr_q <= '0;
      base_q  <= '0;
      key_q   <= '0;
      store_q <= 1'b0;
      wb_q    <= '0;
      paddr_q <= '0;
      fault_q <= FLT_NONE;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          vaddr_q <= req_vaddr;
          base_q  <= pt_base;
          key_q   <= req_key;
          store_q <= req_store;
          state   <= ST_RD_REQ;
        end
        ST_RD_REQ: if (mem_req_ready) state <= ST_RD_WAIT;
        ST_RD_WAIT: if (mem_rsp_valid) begin
          fault_q <= chk_fault;
          wb_q    <= chk_wb_word;
          paddr_q <= (chk_fault == FLT_NONE) ?
                     PA_W'({chk_frame, offset}) : '0;
          state   <= chk_need_wb ? ST_WR_REQ : ST_RESP;
        end
        ST_WR_REQ:  if (mem_req_ready) state <= ST_WR_WAIT;
        ST_WR_WAIT: if (mem_rsp_valid) state <= ST_RESP;
        ST_RESP:    if (rsp_ready)     state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state == ST_IDLE);
  assign rsp_valid     = (state == ST_RESP);
  assign rsp_paddr     = paddr_q;
  assign rsp_fault     = fault_q;
  assign mem_req_valid = (state == ST_RD_REQ) || (state == ST_WR_REQ);
  assign mem_req_write = (state == ST_WR_REQ);
  assign mem_req_addr  = entry_addr;
  assign mem_req_wdata = mem_req_write ? wb_q : '0;
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int PTE_W  = 32,
  parameter int OFFS_W = 12,
  parameter int KEY_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PA_W-1:0]  pt_base,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_store,
  input  logic [KEY_W-1:0] req_key,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [1:0]       rsp_fault,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_write,
  output logic [PA_W-1:0]  mem_req_addr,
  output logic [PTE_W-1:0] mem_req_wdata,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_rdata
);
  import pt_pkg::*;
  localparam int VPN_W   = VA_W - OFFS_W;
  localparam int FRAME_W = PTE_W - OFFS_W;
  localparam int ENT_LG  = $clog2(PTE_W / 8);

  logic [VA_W-1:0]    vaddr_q;
  logic [PA_W-1:0]    base_q;
  logic [KEY_W-1:0]   key_q;
  logic               store_q;
  logic [VPN_W-1:0]   vpn;
  logic [OFFS_W-1:0]  offset;
  logic [PA_W-1:0]    entry_addr;
  fault_e             chk_fault;
  logic               chk_need_wb;
  logic [FRAME_W-1:0] chk_frame;
  logic [PTE_W-1:0]   chk_wb_word;

  pt_addr_split #(.VA_W(VA_W), .PA_W(PA_W), .OFFS_W(OFFS_W), .ENT_LG(ENT_LG)) u_split (
    .vaddr(vaddr_q), .base(base_q), .vpn(vpn), .offset(offset), .entry_addr(entry_addr)
  );

  pt_entry_check #(.PTE_W(PTE_W), .OFFS_W(OFFS_W), .KEY_W(KEY_W)) u_check (
    .entry(mem_rsp_rdata), .key(key_q), .store(store_q), .fault(chk_fault),
    .need_wb(chk_need_wb), .frame(chk_frame), .wb_word(chk_wb_word)
  );

  pt_seq #(.VA_W(VA_W), .PA_W(PA_W), .PTE_W(PTE_W), .OFFS_W(OFFS_W), .KEY_W(KEY_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .pt_base(pt_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_store(req_store), .req_key(req_key),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .vaddr_q(vaddr_q), .base_q(base_q), .key_q(key_q), .store_q(store_q),
    .entry_addr(entry_addr), .offset(offset),
    .chk_fault(chk_fault), .chk_need_wb(chk_need_wb), .chk_frame(chk_frame), .chk_wb_word(chk_wb_word)
  );

  logic unused_vpn;
  assign unused_vpn = ^vpn;
endmodule

// File: rtl/pt_walker_sva.sv
module pt_walker_sva #(
  parameter int PA_W  = 32,
  parameter int PTE_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [PA_W-1:0]  rsp_paddr,
  input logic [1:0]       rsp_fault,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic             mem_req_write,
  input logic [PA_W-1:0]  mem_req_addr,
  input logic [PTE_W-1:0] mem_req_wdata
);
  assert_single_flight_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_no_accept_while_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

  assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata)));

  assert_missing_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 2'd1) |-> (rsp_paddr == '0));

  assert_wb_dirty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> mem_req_wdata[1]);

  assert_no_mem_while_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !mem_req_valid);
endmodule

bind pt_walker pt_walker_sva #(.PA_W(PA_W), .PTE_W(PTE_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
  .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata)
);

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam int NV = 9;

  typedef struct packed {
    logic [31:0] va;
    logic        st;
    logic [1:0]  key;
    logic [1:0]  flt;
    logic [31:0] pa;
    logic [1:0]  nwr;
  } vec_t;

  // table entries: [1]=ABCDE005 key1 clean, [2]=1234500B key2 dirty,
  // [3]=00000004 unassigned, [4]=FFFFF00D key3 clean
  localparam vec_t VEC [NV] = '{
    '{32'h0000_1234, 1'b0, 2'd1, 2'd0, 32'hABCD_E234, 2'd0},  // R3
    '{32'h0000_2FFF, 1'b0, 2'd2, 2'd0, 32'h1234_5FFF, 2'd0},  // R3 max offset
    '{32'h0000_2000, 1'b1, 2'd2, 2'd0, 32'h1234_5000, 2'd0},  // R7 dirty store
    '{32'h0000_3010, 1'b0, 2'd1, 2'd1, 32'h0000_0000, 2'd0},  // R4
    '{32'h0000_1000, 1'b0, 2'd2, 2'd2, 32'h0000_0000, 2'd0},  // R5
    '{32'h0000_4ABC, 1'b1, 2'd3, 2'd0, 32'hFFFF_FABC, 2'd1},  // R6
    '{32'h0000_4001, 1'b1, 2'd3, 2'd0, 32'hFFFF_F001, 2'd0},  // R7 now dirty
    '{32'h0000_3000, 1'b1, 2'd0, 2'd1, 32'h0000_0000, 2'd0},  // R4 priority over key
    '{32'h0000_1FFF, 1'b1, 2'd0, 2'd2, 32'h0000_0000, 2'd0}   // R5 store, no write
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_store = 1'b0, rsp_ready = 1'b1, mem_rdy = 1'b1, stray = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_key = '0;
  logic req_ready, rsp_valid, mem_req_valid, mem_req_write, mem_rsp_q, mem_rsp_valid;
  logic [31:0] rsp_paddr, mem_req_addr, mem_req_wdata, mem_rdata;
  logic [1:0]  rsp_fault;

  logic [31:0] mem [8];
  int wr_cnt = 0, addr_err = 0, checks = 0, failures = 0;
  logic [31:0] exp_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker u_dut (
    .clk(clk), .rst_n(rst_n), .pt_base(BASE),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_store(req_store), .req_key(req_key),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_rdy), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rdata)
  );

  assign mem_rsp_valid = mem_rsp_q | stray;

  always @(posedge clk) begin
    mem_rsp_q <= 1'b0;
    if (rst_n && mem_req_valid && mem_rdy) begin
      mem_rsp_q <= 1'b1;
      if (mem_req_addr != exp_addr) addr_err <= addr_err + 1;
      if (mem_req_write) begin
        mem[3'((mem_req_addr - BASE) >> 2)] <= mem_req_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rdata <= mem[3'((mem_req_addr - BASE) >> 2)];
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_rsp();
    int n = 0;
    while (!rsp_valid && n < 200) begin @(negedge clk); n++; end
    if (!rsp_valid) chk("R8 response timeout", 32'd0, 32'd1);
  endtask

  task automatic xlate(input vec_t v, input string tag);
    int w0 = wr_cnt, e0 = addr_err;
    @(negedge clk);
    exp_addr  = BASE + {10'd0, v.va[31:12], 2'b00};
    req_vaddr = v.va; req_store = v.st; req_key = v.key; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R8 busy after accept"}, {31'd0, req_ready}, 32'd0);
    wait_rsp();
    chk({tag, " R3/R4/R5 fault"}, {30'd0, rsp_fault}, {30'd0, v.flt});
    chk({tag, " R3 paddr"}, rsp_paddr, v.pa);
    chk({tag, " R6/R7 write count"}, wr_cnt - w0, {30'd0, v.nwr});
    chk({tag, " R2 entry address"}, addr_err - e0, 32'd0);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    mem[0] = 32'h0; mem[1] = 32'hABCD_E005; mem[2] = 32'h1234_500B;
    mem[3] = 32'h0000_0004; mem[4] = 32'hFFFF_F00D;
    mem[5] = 32'h0; mem[6] = 32'h0; mem[7] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 req_ready", {31'd0, req_ready}, 32'd1);
    chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R1 mem_req_valid", {31'd0, mem_req_valid}, 32'd0);

    foreach (VEC[i]) xlate(VEC[i], $sformatf("vec%0d", i));
    chk("R6 entry now dirty", mem[4], 32'hFFFF_F00F);
    chk("R7 dirty entry unchanged", mem[2], 32'h1234_500B);

    // R10 stray memory reply while idle
    stray = 1'b1; @(negedge clk); stray = 1'b0; @(negedge clk);
    chk("R10 no response from stray", {31'd0, rsp_valid}, 32'd0);
    chk("R10 no memory command", {31'd0, mem_req_valid}, 32'd0);
    xlate('{32'h0000_1ABC, 1'b0, 2'd1, 2'd0, 32'hABCD_EABC, 2'd0}, "R10 after stray");

    // R9 response back-pressure
    rsp_ready = 1'b0;
    @(negedge clk);
    exp_addr = BASE + 32'd8;
    req_vaddr = 32'h0000_2345; req_store = 1'b0; req_key = 2'd2; req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    wait_rsp();
    repeat (3) @(negedge clk);
    chk("R9 rsp held", {31'd0, rsp_valid}, 32'd1);
    chk("R9 paddr held", rsp_paddr, 32'h1234_5345);
    chk("R8 no accept while rsp pending", {31'd0, req_ready}, 32'd0);
    rsp_ready = 1'b1; @(negedge clk);
    chk("R8 idle after take", {31'd0, req_ready}, 32'd1);

    // R9 memory stall, with a clean-entry store (R6) under stall
    mem_rdy = 1'b0;
    @(negedge clk);
    exp_addr = BASE + 32'd4;
    req_vaddr = 32'h0000_1777; req_store = 1'b1; req_key = 2'd1; req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 mem cmd held", {31'd0, mem_req_valid}, 32'd1);
    chk("R2 stalled address", mem_req_addr, BASE + 32'd4);
    mem_rdy = 1'b1;
    wait_rsp();
    chk("R6 stalled store paddr", rsp_paddr, 32'hABCD_E777);
    chk("R6 write-back data", mem[1], 32'hABCD_E007);
    chk("R2 no address errors", addr_err, 32'd0);
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule